// File: doc/BRIEF.md
# I2C Read Response Unpacker

This block sits behind the receive FIFO of a tag-based I2C controller. When a long read has been split into blocks of at most 256 payload bytes, the controller returns each block as a run of 32-bit words. Each block begins with two tag bytes, and its last word may be padded after the payload. The unpacker takes those words and removes the two tag bytes from the front of every block. It also drops any bytes left in the word that ends a block. What remains is a clean stream of payload bytes.

Software or a sequencer pulses `start_i` with the total message length. The block then works out the size of each block by itself: 256 payload bytes per block, with the final block carrying whatever remains. Bytes leave one per handshake on the output stream. `byte_last_o` marks the final payload byte, and `done_o` pulses once after that byte has been taken. A word is fetched only when every useful byte of the previous word has been used, so the downstream consumer can throttle the controller's FIFO.

Top module: `i2c_rd_unpack`

## Requirements
- R1: While reset is applied, and until the first start is accepted, `word_ready_o`, `byte_valid_o` and `done_o` are low.
- R2: A start pulse is accepted only when idle and `msg_len_i` is nonzero. A start pulse with a length of zero has no effect: `word_ready_o` stays low and no `done_o` pulse follows.
- R3: In every block, the first two bytes taken from the input (the tag bytes) never appear on the output.
- R4: Within a word, bytes are used in lane order: bits 7:0 first, then 15:8, 23:16 and 31:24.
- R5: Every block carries 256 payload bytes except the final one. The final block carries the message length mod 256 bytes, or 256 bytes when that remainder is zero.
- R6: When a block's payload is complete, the rest of the current word is dropped, and the next block starts at lane 0 of a new word.
- R7: An input word is accepted only while a transfer is active and no unsent byte of an earlier word is held. `word_ready_o` and `byte_valid_o` are never high together.
- R8: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_valid_o` stays high and `byte_data_o` holds its value on the next cycle.
- R9: `byte_last_o` is high on the final payload byte of the message and on no other byte. `done_o` is high for exactly the one cycle after that byte's handshake.
- R10: A start pulse during an active transfer is ignored. The byte stream and the word count follow the length captured at the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a read transfer |
| msg_len_i | input | LEN_W | Total payload bytes of the read |
| word_valid_i | input | 1 | Input word available |
| word_data_i | input | WORD_W | Input word from the receive FIFO |
| word_ready_o | output | 1 | Input word accepted this cycle |
| byte_valid_o | output | 1 | Payload byte available |
| byte_data_o | output | 8 | Payload byte |
| byte_last_o | output | 1 | Final payload byte of the message |
| byte_ready_i | input | 1 | Consumer takes the byte |
| done_o | output | 1 | One-cycle pulse after the final byte |

## Verification
The assertions assume three things about the inputs. First, the word source presents exactly as many words as the framed response contains: two tag bytes plus payload per block, padded to a word boundary. Second, it never offers a word beyond that count. Third, `byte_ready_i` may be deasserted at any cycle without limit. The stimulus builds each response from the captured length using the framing in R3 through R6, so the source never runs ahead of the framing. Random gaps in word validity and random consumer stalls are drawn from a fixed seed. A stray start pulse is injected only while a transfer is already running.

// File: rtl/i2c_rd_unpack_pkg.sv
package i2c_rd_unpack_pkg;
  localparam int BYTE_W = 8;
  localparam int TAG_BYTES = 2;
endpackage

// File: rtl/rdu_word_hold.sv
module rdu_word_hold #(
  parameter int WORD_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       load,
  input  logic [WORD_W-1:0]          word_in,
  input  logic                       adv,
  input  logic                       drop,
  output logic                       have_word,
  output logic [i2c_rd_unpack_pkg::BYTE_W-1:0] cur_byte
);
  import i2c_rd_unpack_pkg::*;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(LANES - 1);

  logic [WORD_W-1:0] word_q, word_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              have_q, have_d;
  logic [BYTE_W-1:0] lane_bytes [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_bytes[g] = word_q[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    word_d = word_q;
    lane_d = lane_q;
    have_d = have_q;
    if (clr) begin
      have_d = 1'b0;
      lane_d = '0;
    end else if (load) begin
      word_d = word_in;
      lane_d = '0;
      have_d = 1'b1;
    end else if (adv) begin
      if (drop || lane_q == LANE_TOP) begin
        have_d = 1'b0;
        lane_d = '0;
      end else begin
        lane_d = lane_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lane_q <= '0;
      have_q <= 1'b0;
    end else begin
      word_q <= word_d;
      lane_q <= lane_d;
      have_q <= have_d;
    end
  end

  assign have_word = have_q;
  assign cur_byte  = lane_bytes[lane_q];
endmodule

// File: rtl/rdu_block_track.sv
module rdu_block_track #(
  parameter int LEN_W   = 16,
  parameter int BLK_MAX = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             tag_step,
  input  logic             pay_step,
  output logic             busy,
  output logic             in_tag,
  output logic             blk_end,
  output logic             final_byte,
  output logic             done
);
  import i2c_rd_unpack_pkg::*;
  localparam int BLK_W = $clog2(BLK_MAX + 1);
  localparam int TAG_W = $clog2(TAG_BYTES + 1);

  logic [LEN_W-1:0] rem_q, rem_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  function automatic logic [BLK_W-1:0] blk_size(input logic [LEN_W-1:0] r);
    if (r > LEN_W'(BLK_MAX)) blk_size = BLK_W'(BLK_MAX);
    else                     blk_size = r[BLK_W-1:0];
  endfunction

  always_comb begin
    rem_d  = rem_q;
    blk_d  = blk_q;
    tag_d  = tag_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start && !busy_q) begin
      rem_d  = msg_len;
      blk_d  = blk_size(msg_len);
      tag_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (tag_step) tag_d = tag_q + 1'b1;
      if (pay_step) begin
        rem_d = rem_q - 1'b1;
        if (blk_q == BLK_W'(1)) begin
          if (rem_q == LEN_W'(1)) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            blk_d = blk_size(rem_q - 1'b1);
            tag_d = '0;
          end
        end else begin
          blk_d = blk_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      blk_q  <= '0;
      tag_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      blk_q  <= blk_d;
      tag_q  <= tag_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy       = busy_q;
  assign in_tag     = (tag_q < TAG_W'(TAG_BYTES));
  assign blk_end    = (blk_q == BLK_W'(1));
  assign final_byte = (rem_q == LEN_W'(1));
  assign done       = done_q;
endmodule

// File: rtl/i2c_rd_unpack.sv
module i2c_rd_unpack #(
  parameter int WORD_W  = 32,
  parameter int LEN_W   = 16,
  parameter int BLK_MAX = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  msg_len_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_data_o,
  output logic              byte_last_o,
  input  logic              byte_ready_i,
  output logic              done_o
);
  logic rst_meta_q, rst_sync_n;
  logic busy, in_tag, blk_end, final_byte, done;
  logic have_word, adv, load, tag_step, pay_step, start_ok;
  logic [7:0] cur_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign start_ok = start_i && (msg_len_i != '0);
  assign load     = word_ready_o && word_valid_i;
  assign adv      = have_word && (in_tag || byte_ready_i);
  assign tag_step = have_word && in_tag;
  assign pay_step = have_word && !in_tag && byte_ready_i;

  rdu_block_track #(.LEN_W(LEN_W), .BLK_MAX(BLK_MAX)) u_track (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start_ok),
    .msg_len    (msg_len_i),
    .tag_step   (tag_step),
    .pay_step   (pay_step),
    .busy       (busy),
    .in_tag     (in_tag),
    .blk_end    (blk_end),
    .final_byte (final_byte),
    .done       (done)
  );

  rdu_word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (!busy),
    .load      (load),
    .word_in   (word_data_i),
    .adv       (adv),
    .drop      (pay_step && blk_end),
    .have_word (have_word),
    .cur_byte  (cur_byte)
  );

  assign word_ready_o = busy && !have_word;
  assign byte_valid_o = have_word && !in_tag;
  assign byte_data_o  = cur_byte;
  assign byte_last_o  = byte_valid_o && final_byte;
  assign done_o       = done;
endmodule

// File: rtl/i2c_rd_unpack_chk.sv
module i2c_rd_unpack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       word_ready_o,
  input logic       byte_valid_o,
  input logic [7:0] byte_data_o,
  input logic       byte_last_o,
  input logic       byte_ready_i,
  input logic       done_o
);
  assert_fetch_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready_o |-> !byte_valid_o);

  assert_hold_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o)));

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && byte_ready_i && byte_last_o) |=> done_o);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!byte_valid_o && !word_ready_o));
endmodule

bind i2c_rd_unpack i2c_rd_unpack_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .word_ready_o (word_ready_o),
  .byte_valid_o (byte_valid_o),
  .byte_data_o  (byte_data_o),
  .byte_last_o  (byte_last_o),
  .byte_ready_i (byte_ready_i),
  .done_o       (done_o)
);

// File: tb/sim_i2c_rd_unpack.sv
`timescale 1ns/1ps
module sim_i2c_rd_unpack;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  logic clk, rst_n, start_i, word_valid_i, byte_ready_i;
  logic [LEN_W-1:0] msg_len_i;
  logic [31:0] word_data_i;
  logic word_ready_o, byte_valid_o, byte_last_o, done_o;
  logic [7:0] byte_data_o;

  int checks = 0;
  int failures = 0;

  i2c_rd_unpack u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .msg_len_i(msg_len_i),
    .word_valid_i(word_valid_i), .word_data_i(word_data_i),
    .word_ready_o(word_ready_o), .byte_valid_o(byte_valid_o),
    .byte_data_o(byte_data_o), .byte_last_o(byte_last_o),
    .byte_ready_i(byte_ready_i), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // payload bytes of the block starting at remaining count r (R5)
  function automatic int blk_len(input int r);
    return (r > 256) ? 256 : r;
  endfunction

  logic [31:0] wq[$];
  logic [7:0]  ep[$];

  // frame: two tags, payload, pad to word; lanes low first (R3 R4 R6)
  task automatic build(input int len);
    int r;
    logic [7:0] bq[$];
    wq.delete(); ep.delete();
    r = len;
    while (r > 0) begin
      int n;
      n = blk_len(r);
      bq.delete();
      bq.push_back(8'h85); bq.push_back(8'($urandom));
      for (int i = 0; i < n; i++) begin
        logic [7:0] b;
        b = 8'($urandom);
        bq.push_back(b); ep.push_back(b);
      end
      while (bq.size() % 4 != 0) bq.push_back(8'($urandom));
      for (int w = 0; w < bq.size() / 4; w++)
        wq.push_back({bq[4*w+3], bq[4*w+2], bq[4*w+1], bq[4*w]});
      r -= n;
    end
  endtask

  task automatic run_msg(input int len, input bit mid_start, input bit stall);
    int wi = 0, bi = 0, bad = 0, gate_bad = 0, hold_bad = 0;
    int last_cyc = -10, done_cyc = -1, last_cnt = 0;
    bit hold_pend = 0;
    logic [7:0] hold_val = 0;
    build(len);
    @(negedge clk);
    start_i = 1'b1; msg_len_i = LEN_W'(len);
    word_valid_i = 1'b0; byte_ready_i = 1'b0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      start_i = mid_start && (cyc == 12);
      msg_len_i = LEN_W'(len + 7);
      word_valid_i = (wi < wq.size()) && (!stall || ($urandom % 4 != 0));
      word_data_i = (wi < wq.size()) ? wq[wi] : 32'h0;
      byte_ready_i = !stall || ($urandom % 3 != 0);
      #1;
      if (done_o) begin done_cyc = cyc; break; end
      if (word_ready_o && byte_valid_o) gate_bad++;
      if (hold_pend && !(byte_valid_o && byte_data_o == hold_val)) hold_bad++;
      hold_pend = byte_valid_o && !byte_ready_i;
      hold_val = byte_data_o;
      if (word_valid_i && word_ready_o) wi++;
      if (byte_valid_o && byte_ready_i) begin
        if (bi >= len || byte_data_o != ep[bi]) bad++;
        if (byte_last_o) begin
          last_cnt++;
          if (bi != len - 1) bad++;
          last_cyc = cyc;
        end
        bi++;
      end
    end
    check(done_cyc >= 0, "R9 done seen (watchdog)", done_cyc, 1);
    check(bad == 0, "R3 R4 R5 R6 payload stream", bad, 0);
    check(bi == len, "R5 byte count", bi, len);
    check(wi == wq.size(), "R6 R10 words consumed", wi, wq.size());
    check(last_cnt == 1, "R9 last count", last_cnt, 1);
    check(done_cyc == last_cyc + 1, "R9 done timing", done_cyc, last_cyc + 1);
    check(gate_bad == 0, "R7 fetch gate", gate_bad, 0);
    check(hold_bad == 0, "R8 byte hold", hold_bad, 0);
    @(negedge clk); #1;
    check(!done_o && !word_ready_o, "R9 done single", done_o, 0);
    word_valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    rst_n = 1'b0; start_i = 1'b0; msg_len_i = '0;
    word_valid_i = 1'b0; word_data_i = '0; byte_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!word_ready_o && !byte_valid_o && !done_o, "R1 in reset", word_ready_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!word_ready_o && !byte_valid_o && !done_o, "R1 after release", byte_valid_o, 0);

    // R2: zero length start ignored
    start_i = 1'b1; msg_len_i = '0;
    @(negedge clk); start_i = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk); #1;
        if (word_ready_o || done_o) seen++;
      end
      check(seen == 0, "R2 zero length", seen, 0);
    end

    run_msg(1, 0, 0);
    run_msg(2, 0, 1);
    run_msg(3, 1, 1);
    run_msg(4, 0, 1);
    run_msg(6, 0, 0);
    run_msg(255, 0, 1);
    run_msg(256, 1, 1);
    run_msg(257, 0, 1);
    run_msg(512, 0, 0);
    run_msg(513, 1, 1);
    for (int k = 0; k < 8; k++) run_msg(1 + int'($urandom % 700), k[0], 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule